// File: doc/BRIEF.md
# Endian-Configurable Load/Store Alignment Unit

This unit sits between a 32-bit core and a data memory that is organised in 32-bit words but addressed in bytes. For each byte, halfword or word load or store, it turns the byte address into a word address. It also produces a byte-lane enable mask and steers the data. Store data is placed into the correct lanes. For loads, the addressed field is taken from the returned word and sign- or zero-extended to 32 bits.

Byte ordering is a strap. It is sampled once, as the unit leaves reset, and stays fixed until the next reset. In big-endian mode the lowest-addressed byte of a word is its most significant byte. In little-endian mode that byte is the least significant one. An access whose address is not a multiple of its size is not performed. It is reported as a trap, and the faulting address is kept for the trap handler.

The memory read is synchronous: data asked for in one cycle comes back on `mem_rdata_i` in the next cycle. The extended load result appears in that same next cycle. The core must not issue a request in the first cycle after reset is released.

Top module: `mem_lane_align`

## Requirements
- R1: `mem_addr_o` equals `addr_i` with its two low bits forced to zero.
- R2: `big_endian_i` is sampled on the first rising clock edge after `rst_ni` deasserts (1 = big endian, 0 = little endian). Later changes have no effect until the next reset.
- R3: In little-endian mode, the byte at address offset k (k = `addr_i[1:0]`) uses lane k, that is data bits 8k+7..8k. A halfword at offset 0 uses bits 15..0, and one at offset 2 uses bits 31..16.
- R4: In big-endian mode, the byte at offset k uses lane 3-k. A halfword at offset 0 uses bits 31..16, with its high byte at the lower address. A halfword at offset 2 uses bits 15..0.
- R5: A store (`we_i`=1) raises `mem_we_o` and sets one, two or four bits of `mem_be_o` for a byte, halfword or word. The store data is replicated so that the selected lanes carry it. Size encoding: 00 byte, 01 halfword, 10 word, 11 treated as word.
- R6: A load (`we_i`=0) raises `mem_re_o`. In the following cycle, `load_valid_o` is 1 and `load_data_o` holds the addressed field. The field is sign-extended when `unsigned_i`=0 and zero-extended when `unsigned_i`=1.
- R7: A word needs `addr_i[1:0]`=00 and a halfword needs `addr_i[0]`=0. A byte access is always aligned.
- R8: A misaligned request drives neither `mem_we_o` nor `mem_re_o`, and `mem_be_o` is zero. `misalign_o` is high for exactly the next cycle. `fault_addr_o` takes the full byte address at that point and holds it until the next misaligned request.
- R9: Out of reset, `misalign_o`, `load_valid_o` and `fault_addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | Byte-order strap, sampled as reset is left |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access size: 00 byte, 01 half, 10/11 word |
| unsigned_i | input | 1 | Zero-extend narrow loads |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Store data, right-justified |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read strobe |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Lane-steered store data |
| mem_rdata_i | input | 32 | Read word, one cycle after the read strobe |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Extended load result |
| misalign_o | output | 1 | Misaligned-access trap pulse |
| fault_addr_o | output | ADDR_W | Byte address of the last misaligned access |

## Verification
The assertions check on every cycle that a trapped request never reaches memory and that each trap produces its pulse. They also check that the fault address changes only on a new trap, that a store enables as many lanes as its size, that every read strobe is followed by a valid load result, and that the byte order stays frozen once reset has been left. Which lane a given offset maps to in each byte order, the replicated store data, and the sign or zero extension of loaded fields can only be shown by the bench. It runs store and load scenarios under both strap values and compares them with a byte-addressed reference. The same applies to the strap being ignored after reset.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // bytes in access minus one
  function automatic int size_m1(acc_size_e sz, int nb);
    case (sz)
      SZ_BYTE: return 0;
      SZ_HALF: return 1;
      default: return nb - 1;
    endcase
  endfunction
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_align_pkg::*;
#(
  parameter int NB = 4,
  localparam int LW = $clog2(NB)
) (
  input  acc_size_e      size_i,
  input  logic [LW-1:0]  off_i,
  output logic           misaligned_o
);
  always_comb begin
    case (size_i)
      SZ_BYTE: misaligned_o = 1'b0;
      SZ_HALF: misaligned_o = off_i[0];
      default: misaligned_o = |off_i;
    endcase
  end
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
  import lsu_align_pkg::*;
#(
  parameter int NB = 4,
  localparam int LW = $clog2(NB)
) (
  input  acc_size_e      size_i,
  input  logic [LW-1:0]  off_i,
  input  logic           big_i,
  output logic [LW-1:0]  lane_lo_o,
  output logic [NB-1:0]  be_o
);
  int m1;
  logic [NB-1:0] base_mask;

  always_comb begin
    m1        = size_m1(size_i, NB);
    base_mask = ~({NB{1'b1}} << (m1 + 1));
    // big endian: lowest address lands in highest lane of the field
    if (big_i) lane_lo_o = LW'(NB - 1 - int'(off_i) - m1);
    else       lane_lo_o = off_i;
    be_o = base_mask << lane_lo_o;
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_align_pkg::*;
#(
  parameter int NB = 4,
  localparam int DATA_W = NB * 8
) (
  input  acc_size_e          size_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  wdata_o
);
  logic [DATA_W-1:0] rep_byte, rep_half;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_byte
      assign rep_byte[g*8 +: 8] = wdata_i[7:0];
    end
    for (g = 0; g < NB/2; g++) begin : g_half
      assign rep_half[g*16 +: 16] = wdata_i[15:0];
    end
  endgenerate

  always_comb begin
    case (size_i)
      SZ_BYTE: wdata_o = rep_byte;
      SZ_HALF: wdata_o = rep_half;
      default: wdata_o = wdata_i;
    endcase
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int NB = 4,
  localparam int LW = $clog2(NB),
  localparam int DATA_W = NB * 8
) (
  input  logic [DATA_W-1:0]  rdata_i,
  input  logic [LW-1:0]      lane_lo_i,
  input  acc_size_e          size_i,
  input  logic               uns_i,
  output logic [DATA_W-1:0]  data_o
);
  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = rdata_i >> {lane_lo_i, 3'b000};
    case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-8){~uns_i & shifted[7]}}, shifted[7:0]};
      SZ_HALF: data_o = {{(DATA_W-16){~uns_i & shifted[15]}}, shifted[15:0]};
      default: data_o = shifted;
    endcase
  end
endmodule

// File: rtl/mem_lane_align.sv
module mem_lane_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_endian_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              load_valid_o,
  output logic [31:0]       load_data_o,
  output logic              misalign_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  localparam int NB = 4;
  localparam int LW = $clog2(NB);

  acc_size_e      size_w;
  logic [LW-1:0]  off_w, lane_lo_w;
  logic [NB-1:0]  be_w;
  logic           mis_w, acc_ok;

  logic           in_rst_q, big_q;
  logic           misalign_q;
  logic [ADDR_W-1:0] fault_q;
  logic           ld_pend_q, ld_uns_q;
  logic [LW-1:0]  ld_lane_q;
  acc_size_e      ld_size_q;

  assign size_w = acc_size_e'(size_i);
  assign off_w  = addr_i[LW-1:0];

  lsu_align_check #(.NB(NB)) u_check (
    .size_i(size_w), .off_i(off_w), .misaligned_o(mis_w)
  );

  lsu_lane_map #(.NB(NB)) u_map (
    .size_i(size_w), .off_i(off_w), .big_i(big_q),
    .lane_lo_o(lane_lo_w), .be_o(be_w)
  );

  lsu_store_steer #(.NB(NB)) u_steer (
    .size_i(size_w), .wdata_i(wdata_i), .wdata_o(mem_wdata_o)
  );

  lsu_load_extract #(.NB(NB)) u_extract (
    .rdata_i(mem_rdata_i), .lane_lo_i(ld_lane_q), .size_i(ld_size_q),
    .uns_i(ld_uns_q), .data_o(load_data_o)
  );

  assign acc_ok     = req_i & ~mis_w;
  assign mem_we_o   = acc_ok & we_i;
  assign mem_re_o   = acc_ok & ~we_i;
  assign mem_be_o   = acc_ok ? be_w : '0;
  assign mem_addr_o = {addr_i[ADDR_W-1:LW], {LW{1'b0}}};

  // byte-order strap: captured once, on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rst_q <= 1'b1;
      big_q    <= 1'b0;
    end else begin
      in_rst_q <= 1'b0;
      if (in_rst_q) big_q <= big_endian_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      misalign_q <= 1'b0;
      fault_q    <= '0;
      ld_pend_q  <= 1'b0;
      ld_lane_q  <= '0;
      ld_size_q  <= SZ_BYTE;
      ld_uns_q   <= 1'b0;
    end else begin
      misalign_q <= req_i & mis_w;
      if (req_i && mis_w) fault_q <= addr_i;
      ld_pend_q <= mem_re_o;
      if (mem_re_o) begin
        ld_lane_q <= lane_lo_w;
        ld_size_q <= size_w;
        ld_uns_q  <= unsigned_i;
      end
    end
  end

  assign misalign_o   = misalign_q;
  assign fault_addr_o = fault_q;
  assign load_valid_o = ld_pend_q;

  assert_endian_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rst_q |=> $stable(big_q));

  assert_lane_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $countones(mem_be_o) ==
      (size_i == 2'b00 ? 1 : (size_i == 2'b01 ? 2 : NB)));

  assert_load_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> load_valid_o);

  assert_no_mem_on_trap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mis_w) |-> (!mem_we_o && !mem_re_o && mem_be_o == '0));

  assert_trap_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mis_w) |=> misalign_o);

  assert_fault_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && mis_w) |=> $stable(fault_addr_o));

  assert_word_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i[1] && addr_i[1:0] != 2'b00) |=> misalign_o);
endmodule

// File: tb/mem_lane_align_test.sv
module mem_lane_align_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        big_endian_i = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, unsigned_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, load_data_o, fault_addr_o;
  logic        mem_we_o, mem_re_o, load_valid_o, misalign_o;
  logic [3:0]  mem_be_o;

  int n_checks = 0;
  int n_err = 0;

  logic [31:0] mem [16];
  logic [31:0] rdata_q = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_lane_align uut (
    .clk_i(clk), .rst_ni(rst_ni), .big_endian_i(big_endian_i),
    .req_i(req_i), .we_i(we_i), .size_i(size_i), .unsigned_i(unsigned_i),
    .addr_i(addr_i), .wdata_i(wdata_i),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .load_valid_o(load_valid_o), .load_data_o(load_data_o),
    .misalign_o(misalign_o), .fault_addr_o(fault_addr_o)
  );

  // synchronous-read memory model
  always_ff @(posedge clk) begin
    if (mem_we_o)
      for (int b = 0; b < 4; b++)
        if (mem_be_o[b]) mem[mem_addr_o[5:2]][b*8 +: 8] <= mem_wdata_o[b*8 +: 8];
    if (mem_re_o) rdata_q <= mem[mem_addr_o[5:2]];
  end
  assign mem_rdata_i = rdata_q;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  // lane holding the byte at word offset k
  function automatic int lane_of(input int k, input bit big);
    return big ? 3 - k : k;
  endfunction

  function automatic logic [3:0] exp_be(input int off, input logic [1:0] sz, input bit big);
    logic [3:0] m = '0;
    for (int i = 0; i < nbytes(sz); i++) m[lane_of(off + i, big)] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] w, input int off,
                                           input logic [1:0] sz, input bit uns, input bit big);
    logic [31:0] v = '0;
    int nb = nbytes(sz);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b = w[lane_of(off + i, big)*8 +: 8];
      if (big) v[(nb-1-i)*8 +: 8] = b;
      else     v[i*8 +: 8] = b;
    end
    if (!uns && nb == 1) v = {{24{v[7]}}, v[7:0]};
    if (!uns && nb == 2) v = {{16{v[15]}}, v[15:0]};
    return v;
  endfunction

  task automatic do_reset(input bit big);
    @(negedge clk);
    rst_ni = 1'b0;
    req_i = 1'b0;
    big_endian_i = big;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_store(input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input bit big, input string tag);
    logic [3:0] eb;
    int off = int'(a[1:0]);
    int nb = nbytes(sz);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; size_i = sz; addr_i = a; wdata_i = d;
    #1;
    eb = exp_be(off, sz, big);
    chk(mem_we_o === 1'b1 && mem_re_o === 1'b0, {tag, " R5 we"},
        {30'd0, mem_we_o, mem_re_o}, 32'd2);
    chk(mem_be_o === eb, {tag, " R5 be"}, {28'd0, mem_be_o}, {28'd0, eb});
    for (int i = 0; i < nb; i++) begin
      int ln = lane_of(off + i, big);
      logic [7:0] eb8 = big ? d[(nb-1-i)*8 +: 8] : d[i*8 +: 8];
      chk(mem_wdata_o[ln*8 +: 8] === eb8, {tag, big ? " R4 lane" : " R3 lane"},
          {24'd0, mem_wdata_o[ln*8 +: 8]}, {24'd0, eb8});
    end
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] a, input logic [1:0] sz, input bit uns,
                         input bit big, input string tag);
    logic [31:0] w = mem[a[5:2]];
    logic [31:0] ev = exp_load(w, int'(a[1:0]), sz, uns, big);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; size_i = sz; unsigned_i = uns; addr_i = a;
    #1;
    chk(mem_re_o === 1'b1 && mem_we_o === 1'b0, {tag, " R6 re"},
        {30'd0, mem_we_o, mem_re_o}, 32'd1);
    @(negedge clk);
    req_i = 1'b0;
    chk(load_valid_o === 1'b1, {tag, " R6 valid"}, {31'd0, load_valid_o}, 32'd1);
    chk(load_data_o === ev, {tag, big ? " R4 R6 data" : " R3 R6 data"}, load_data_o, ev);
  endtask

  task automatic t_reset_state;
    chk(misalign_o === 1'b0, "R9 misalign", {31'd0, misalign_o}, 32'd0);
    chk(load_valid_o === 1'b0, "R9 load_valid", {31'd0, load_valid_o}, 32'd0);
    chk(fault_addr_o === 32'd0, "R9 fault_addr", fault_addr_o, 32'd0);
  endtask

  task automatic t_word_addr;
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; size_i = 2'b00; addr_i = 32'h0000_1237;
    #1;
    chk(mem_addr_o === 32'h0000_1234, "R1 word addr", mem_addr_o, 32'h0000_1234);
    addr_i = 32'hFFFF_FFFE; size_i = 2'b01;
    #1;
    chk(mem_addr_o === 32'hFFFF_FFFC, "R1 word addr high", mem_addr_o, 32'hFFFF_FFFC);
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic t_misalign(input logic [31:0] a, input logic [1:0] sz, input bit st,
                            input string tag);
    @(negedge clk);
    req_i = 1'b1; we_i = st; size_i = sz; addr_i = a; wdata_i = 32'hDEAD_BEEF;
    #1;
    chk(mem_we_o === 1'b0 && mem_re_o === 1'b0 && mem_be_o === 4'h0,
        {tag, " R8 no access"}, {26'd0, mem_we_o, mem_re_o, mem_be_o}, 32'd0);
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
    chk(misalign_o === 1'b1, {tag, " R7 R8 pulse"}, {31'd0, misalign_o}, 32'd1);
    chk(fault_addr_o === a, {tag, " R8 fault addr"}, fault_addr_o, a);
    chk(load_valid_o === 1'b0, {tag, " R8 no load"}, {31'd0, load_valid_o}, 32'd0);
    @(negedge clk);
    chk(misalign_o === 1'b0, {tag, " R8 one cycle"}, {31'd0, misalign_o}, 32'd0);
    chk(fault_addr_o === a, {tag, " R8 hold"}, fault_addr_o, a);
  endtask

  task automatic t_aligned_no_trap;
    // byte at odd offset is aligned; fault address must not move
    logic [31:0] held = fault_addr_o;
    do_load(32'h0000_000B, 2'b00, 1'b1, 1'b0, "byte odd");
    chk(misalign_o === 1'b0, "R7 byte never traps", {31'd0, misalign_o}, 32'd0);
    chk(fault_addr_o === held, "R8 fault held over good access", fault_addr_o, held);
  endtask

  task automatic t_little;
    mem[2] = 32'h80F1_7F02;
    do_load(32'h0000_0009, 2'b00, 1'b0, 1'b0, "LE byte+");
    do_load(32'h0000_000A, 2'b00, 1'b0, 1'b0, "LE byte-");
    do_load(32'h0000_000A, 2'b00, 1'b1, 1'b0, "LE ubyte");
    do_load(32'h0000_000A, 2'b01, 1'b0, 1'b0, "LE half-");
    do_load(32'h0000_0008, 2'b01, 1'b1, 1'b0, "LE uhalf");
    do_load(32'h0000_0008, 2'b10, 1'b0, 1'b0, "LE word");
    mem[3] = 32'h0;
    do_store(32'h0000_000E, 2'b00, 32'h0000_00A5, 1'b0, "LE st byte");
    do_store(32'h0000_000C, 2'b01, 32'h0000_1234, 1'b0, "LE st half");
    do_load(32'h0000_000C, 2'b10, 1'b0, 1'b0, "LE st readback");
    chk(mem[3] === 32'h00A5_1234, "R3 R5 memory image", mem[3], 32'h00A5_1234);
    do_store(32'h0000_0010, 2'b11, 32'hCAFE_F00D, 1'b0, "LE st rsvd-as-word");
  endtask

  task automatic t_strap_ignored;
    big_endian_i = 1'b1;
    do_store(32'h0000_0014, 2'b00, 32'h0000_0077, 1'b0, "R2 strap ignored");
    big_endian_i = 1'b0;
  endtask

  task automatic t_big;
    mem[2] = 32'h80F1_7F02;
    do_load(32'h0000_0008, 2'b00, 1'b0, 1'b1, "BE byte-");
    do_load(32'h0000_000A, 2'b00, 1'b0, 1'b1, "BE byte+");
    do_load(32'h0000_0008, 2'b01, 1'b0, 1'b1, "BE half-");
    do_load(32'h0000_000A, 2'b01, 1'b1, 1'b1, "BE uhalf");
    do_load(32'h0000_0008, 2'b10, 1'b0, 1'b1, "BE word");
    mem[3] = 32'h0;
    do_store(32'h0000_000E, 2'b00, 32'h0000_00A5, 1'b1, "BE st byte");
    do_store(32'h0000_000C, 2'b01, 32'h0000_1234, 1'b1, "BE st half");
    chk(mem[3] === 32'h1234_A500, "R4 R5 memory image", mem[3], 32'h1234_A500);
    do_load(32'h0000_000D, 2'b00, 1'b1, 1'b1, "BE st readback");
    big_endian_i = 1'b0;
    do_store(32'h0000_0014, 2'b00, 32'h0000_0066, 1'b1, "R2 BE strap ignored");
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    do_reset(1'b0);
    t_reset_state();
    t_word_addr();
    t_little();
    t_strap_ignored();
    t_misalign(32'h0000_0203, 2'b10, 1'b0, "word 0x203");
    t_misalign(32'h0000_0106, 2'b10, 1'b1, "word st 0x106");
    t_misalign(32'h0000_000B, 2'b01, 1'b0, "half odd");
    t_aligned_no_trap();
    do_reset(1'b1);
    t_reset_state();
    t_big();
    t_misalign(32'h0000_0021, 2'b01, 1'b1, "BE half st odd");
    finish_run();
  end
endmodule